// File: doc/BRIEF.md
# Timer Clock Select and Gating

This block produces the count-enable pulse for one timer channel. Every register runs on the master clock. Eight candidate sources are available: five internal prescaled taps, which are levels synchronous to the master clock, and three external clock inputs. Each external input goes through a two-flop synchronizer and then an edge detector. The block picks one source and one edge of it, rising or falling under an invert control. It can also hold counting off unless a selected external level is high (burst gating). The result is a one-master-cycle pulse, `cnt_en`, which the channel's counter uses as its increment strobe.

Two layers of run control sit above the source path. The enabled state is set and cleared by software commands, and the capture-load or compare event can also clear it, depending on mode. The started state is set by any trigger and cleared by the mode's stop event. The started state can change only while the clock is enabled. Counting happens only when both states are true. The enabled state is reported on a status output. An external source must hold each level for longer than one master clock period, and its frequency must be no more than the master clock frequency divided by 2.5.

Top module: `tcg_clock_gate`

## Requirements
- R1: After reset, `clk_enabled` is 0, the channel is stopped, and `cnt_en` stays 0 even when the selected source toggles.
- R2: `src_sel` values 0 to 4 pick internal tap `int_clk[src_sel]`, and values 5 to 7 pick `ext_clk[src_sel-5]`. A rising edge of an internal tap seen at master edge k gives `cnt_en` = 1 from edge k to edge k+1. Taps that are not selected produce no pulse.
- R3: With `clk_inv` = 1, the pulse comes from the falling edge of the selected source, and a rising edge produces no pulse.
- R4: An external input passes through two synchronizer flops. When `ext_clk` rises before master edge k, `cnt_en` is high from edge k+2 to edge k+3 and low otherwise.
- R5: `burst_sel` encodes the gate: 0 means no gate, and 1, 2 or 3 mean the synchronized level of `ext_clk[0]`, `ext_clk[1]` or `ext_clk[2]`. While the selected gate level is low, no pulse is produced.
- R6: `cmd_enable` sets the enabled state and `cmd_disable` clears it. When both arrive in the same cycle, disable wins. `clk_enabled` shows the enabled state one cycle after the command.
- R7: With `wave_mode` = 0 (capture), `load_b_evt` clears the enabled state when `ldb_dis` = 1. With `wave_mode` = 1 (waveform), `cmp_c_evt` clears it when `cmpc_dis` = 1. The event that belongs to the other mode has no effect.
- R8: While enabled, `trigger` starts the channel. The mode's event stops it: `load_b_evt` with `ldb_stop` in capture mode, `cmp_c_evt` with `cmpc_stop` in waveform mode. A trigger in the same cycle as a stop event takes effect as a start.
- R9: Triggers and stop events have no effect while the clock is disabled. Disabling also stops the channel, and after a re-enable the channel stays stopped until the next trigger.
- R10: Each selected edge yields a pulse exactly one master cycle long, even when the source stays at its new level for many cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_clk | input | 5 | Internal prescaled clock taps, levels synchronous to `clk` |
| ext_clk | input | 3 | External clock inputs, asynchronous |
| src_sel | input | 3 | Source select (0 to 4 internal, 5 to 7 external) |
| clk_inv | input | 1 | Count on the falling edge when 1 |
| burst_sel | input | 2 | Gate select: 0 none, 1 to 3 external level 0 to 2 |
| wave_mode | input | 1 | 0 capture mode, 1 waveform mode |
| ldb_dis | input | 1 | Capture mode: register-B load disables the clock |
| ldb_stop | input | 1 | Capture mode: register-B load stops the clock |
| cmpc_dis | input | 1 | Waveform mode: register-C compare disables the clock |
| cmpc_stop | input | 1 | Waveform mode: register-C compare stops the clock |
| cmd_enable | input | 1 | Software enable command pulse |
| cmd_disable | input | 1 | Software disable command pulse |
| trigger | input | 1 | Start pulse (software, sync, external or compare trigger) |
| load_b_evt | input | 1 | Register-B load event pulse |
| cmp_c_evt | input | 1 | Register-C compare event pulse |
| cnt_en | output | 1 | One-cycle count-enable pulse |
| clk_enabled | output | 1 | Status: clock enabled |

## Verification
The assertions check these rules on every cycle: disable wins over enable, the enabled state rises only on an enable command, the started state rises only on a trigger and never exists without the enabled state, a same-cycle trigger beats a stop, and every `cnt_en` pulse lasts one cycle and comes from a started channel. Some behaviour shows only in the bench's scenarios: the source and edge chosen by each select and invert setting, the exact two-stage synchronizer latency on an external input, gating by each burst level, and the mode-dependent choice of which event disables or stops the clock.

// File: rtl/tcg_pkg.sv
package tcg_pkg;

   typedef enum logic {
      MODE_CAPTURE  = 1'b0,
      MODE_WAVEFORM = 1'b1
   } tcg_mode_e;

   typedef struct packed {
      logic dis_on_load;
      logic stop_on_load;
      logic dis_on_cmp;
      logic stop_on_cmp;
   } tcg_evt_cfg_t;

endpackage

// File: rtl/tcg_edge_det.sv
module tcg_edge_det #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise,
   output logic fall
);

   logic prev_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign lvl = din;
      end else begin : g_sync
         logic [STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[STAGES-2:0], din};
         end
         assign lvl = sync_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;

endmodule

// File: rtl/tcg_src_mux.sv
module tcg_src_mux #(
   parameter int N_INT = 5,
   parameter int N_EXT = 3,
   localparam int N_SRC = N_INT + N_EXT,
   localparam int SEL_W = $clog2(N_SRC),
   localparam int BST_W = $clog2(N_EXT + 1)
) (
   input  logic [N_SRC-1:0] rise_all,
   input  logic [N_SRC-1:0] fall_all,
   input  logic [N_EXT-1:0] ext_lvl,
   input  logic [SEL_W-1:0] src_sel,
   input  logic             clk_inv,
   input  logic [BST_W-1:0] burst_sel,
   output logic             tick
);

   logic edge_sel;
   logic gate_ok;

   always_comb begin
      edge_sel = 1'b0;
      for (int i = 0; i < N_SRC; i++) begin
         if (int'(src_sel) == i) edge_sel = clk_inv ? fall_all[i] : rise_all[i];
      end
   end

   always_comb begin
      gate_ok = (burst_sel == '0);
      for (int i = 0; i < N_EXT; i++) begin
         if (int'(burst_sel) == i + 1) gate_ok = ext_lvl[i];
      end
   end

   assign tick = edge_sel & gate_ok;

endmodule

// File: rtl/tcg_run_ctrl.sv
module tcg_run_ctrl
   import tcg_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  tcg_mode_e    mode,
   input  tcg_evt_cfg_t cfg,
   input  logic         cmd_en,
   input  logic         cmd_dis,
   input  logic         trig,
   input  logic         ldb_evt,
   input  logic         cmp_evt,
   output logic         en_q,
   output logic         run_q
);

   logic auto_dis;
   logic auto_stop;
   logic en_nx;
   logic run_nx;

   always_comb begin
      if (mode == MODE_WAVEFORM) begin
         auto_dis  = cmp_evt & cfg.dis_on_cmp;
         auto_stop = cmp_evt & cfg.stop_on_cmp;
      end else begin
         auto_dis  = ldb_evt & cfg.dis_on_load;
         auto_stop = ldb_evt & cfg.stop_on_load;
      end
   end

   always_comb begin
      if (cmd_dis || auto_dis) en_nx = 1'b0;
      else if (cmd_en)         en_nx = 1'b1;
      else                     en_nx = en_q;

      if (!en_nx)         run_nx = 1'b0;
      else if (!en_q)     run_nx = run_q;
      else if (trig)      run_nx = 1'b1;
      else if (auto_stop) run_nx = 1'b0;
      else                run_nx = run_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         run_q <= 1'b0;
      end else begin
         en_q  <= en_nx;
         run_q <= run_nx;
      end
   end

   // R6
   en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q) |-> $past(cmd_en && !cmd_dis));

   // R6
   dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_dis |=> !en_q);

   // R9
   run_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> en_q);

   // R8
   start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> $past(trig));

   // R8
   trig_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && trig && !cmd_dis && !auto_dis) |=> run_q);

endmodule

// File: rtl/tcg_clock_gate.sv
module tcg_clock_gate
   import tcg_pkg::*;
#(
   parameter int N_INT       = 5,
   parameter int N_EXT       = 3,
   parameter int SYNC_STAGES = 2,
   localparam int N_SRC = N_INT + N_EXT,
   localparam int SEL_W = $clog2(N_SRC),
   localparam int BST_W = $clog2(N_EXT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_INT-1:0] int_clk,
   input  logic [N_EXT-1:0] ext_clk,
   input  logic [SEL_W-1:0] src_sel,
   input  logic             clk_inv,
   input  logic [BST_W-1:0] burst_sel,
   input  logic             wave_mode,
   input  logic             ldb_dis,
   input  logic             ldb_stop,
   input  logic             cmpc_dis,
   input  logic             cmpc_stop,
   input  logic             cmd_enable,
   input  logic             cmd_disable,
   input  logic             trigger,
   input  logic             load_b_evt,
   input  logic             cmp_c_evt,
   output logic             cnt_en,
   output logic             clk_enabled
);

   generate
      if (N_INT < 1 || N_EXT < 1) begin : g_bad_count
         $error("tcg_clock_gate: needs at least one internal and one external source");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tcg_clock_gate: SYNC_STAGES must be 2 or more");
      end
   endgenerate

   logic [N_SRC-1:0] rise_all;
   logic [N_SRC-1:0] fall_all;
   logic [N_SRC-1:0] lvl_all;
   logic             tick;
   logic             en_st;
   logic             run_st;
   logic             cnt_en_q;
   tcg_evt_cfg_t     evt_cfg;
   tcg_mode_e        mode;

   generate
      for (genvar gi = 0; gi < N_SRC; gi++) begin : g_src
         if (gi < N_INT) begin : g_int
            tcg_edge_det #(.STAGES(0)) u_det (
               .clk  (clk),
               .rst_n(rst_n),
               .din  (int_clk[gi]),
               .lvl  (lvl_all[gi]),
               .rise (rise_all[gi]),
               .fall (fall_all[gi])
            );
         end else begin : g_ext
            tcg_edge_det #(.STAGES(SYNC_STAGES)) u_det (
               .clk  (clk),
               .rst_n(rst_n),
               .din  (ext_clk[gi-N_INT]),
               .lvl  (lvl_all[gi]),
               .rise (rise_all[gi]),
               .fall (fall_all[gi])
            );
         end
      end
   endgenerate

   tcg_src_mux #(.N_INT(N_INT), .N_EXT(N_EXT)) u_mux (
      .rise_all (rise_all),
      .fall_all (fall_all),
      .ext_lvl  (lvl_all[N_SRC-1:N_INT]),
      .src_sel  (src_sel),
      .clk_inv  (clk_inv),
      .burst_sel(burst_sel),
      .tick     (tick)
   );

   assign evt_cfg = '{dis_on_load: ldb_dis, stop_on_load: ldb_stop,
                      dis_on_cmp: cmpc_dis, stop_on_cmp: cmpc_stop};
   assign mode    = wave_mode ? MODE_WAVEFORM : MODE_CAPTURE;

   tcg_run_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (mode),
      .cfg    (evt_cfg),
      .cmd_en (cmd_enable),
      .cmd_dis(cmd_disable),
      .trig   (trigger),
      .ldb_evt(load_b_evt),
      .cmp_evt(cmp_c_evt),
      .en_q   (en_st),
      .run_q  (run_st)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_en_q <= 1'b0;
      else        cnt_en_q <= tick & en_st & run_st;
   end

   assign cnt_en      = cnt_en_q;
   assign clk_enabled = en_st;

   // R10
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en_q |=> !cnt_en_q);

   // R9
   count_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en_q |-> $past(run_st));

endmodule

// File: tb/tcg_clock_gate_test.sv
`timescale 1ns/1ps
module tcg_clock_gate_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] int_clk = '0;
   logic [2:0] ext_clk = '0;
   logic [2:0] src_sel = '0;
   logic       clk_inv = 1'b0;
   logic [1:0] burst_sel = '0;
   logic       wave_mode = 1'b0;
   logic       ldb_dis = 1'b0, ldb_stop = 1'b0, cmpc_dis = 1'b0, cmpc_stop = 1'b0;
   logic       cmd_enable = 1'b0, cmd_disable = 1'b0, trigger = 1'b0;
   logic       load_b_evt = 1'b0, cmp_c_evt = 1'b0;
   logic       cnt_en, clk_enabled;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   tcg_clock_gate uut (
      .clk(clk), .rst_n(rst_n), .int_clk(int_clk), .ext_clk(ext_clk),
      .src_sel(src_sel), .clk_inv(clk_inv), .burst_sel(burst_sel),
      .wave_mode(wave_mode), .ldb_dis(ldb_dis), .ldb_stop(ldb_stop),
      .cmpc_dis(cmpc_dis), .cmpc_stop(cmpc_stop), .cmd_enable(cmd_enable),
      .cmd_disable(cmd_disable), .trigger(trigger), .load_b_evt(load_b_evt),
      .cmp_c_evt(cmp_c_evt), .cnt_en(cnt_en), .clk_enabled(clk_enabled)
   );

   // Bits: [11]enable [10]disable [9]trigger [8]load_b [7]cmp_c [6]wave
   //       [5]ldb_dis [4]ldb_stop [3]cmpc_dis [2]cmpc_stop [1]exp enabled [0]exp counting
   localparam int NV = 20;
   localparam logic [11:0] VEC [NV] = '{
      12'b001_00_0_0000_00,  // trigger while disabled
      12'b100_00_0_0000_10,  // enable, still stopped
      12'b001_00_0_0000_11,  // start
      12'b000_10_0_0100_10,  // capture load stops
      12'b001_00_0_0000_11,  // restart
      12'b000_10_0_1000_00,  // capture load disables
      12'b001_00_0_0000_00,  // trigger ignored while disabled
      12'b110_00_0_0000_00,  // enable and disable together
      12'b100_00_0_0000_10,  // re-enable stays stopped
      12'b001_00_0_0000_11,  // start
      12'b001_01_1_0001_11,  // trigger beats compare stop
      12'b000_01_1_0001_10,  // waveform compare stops
      12'b001_00_0_0000_11,  // start
      12'b000_01_0_0011_11,  // compare in capture mode ignored
      12'b000_10_1_1100_11,  // load in waveform mode ignored
      12'b000_01_1_0010_00,  // waveform compare disables
      12'b000_01_1_0001_00,  // stop while disabled ignored
      12'b100_00_0_0000_10,  // enable
      12'b001_00_0_0000_11,  // start
      12'b001_00_0_0000_11   // start again, no change
   };

   task automatic check(input logic got, input logic exp, input string req);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic clear_ctrl();
      cmd_enable = 0; cmd_disable = 0; trigger = 0; load_b_evt = 0; cmp_c_evt = 0;
   endtask

   task automatic tap_pulse(input int idx, input logic exp, input string req);
      @(negedge clk); int_clk[idx] = 1'b1;
      @(negedge clk); check(cnt_en, exp, req);
      int_clk[idx] = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state, held in reset
      check(clk_enabled, 1'b0, "R1 status in reset");
      check(cnt_en, 1'b0, "R1 cnt_en in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(clk_enabled, 1'b0, "R1 status after reset");
      tap_pulse(0, 1'b0, "R1 no pulse while stopped");

      // R6 R7 R8 R9 command sequence from the table
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {cmd_enable, cmd_disable, trigger, load_b_evt, cmp_c_evt, wave_mode,
          ldb_dis, ldb_stop, cmpc_dis, cmpc_stop} = VEC[i][11:2];
         @(negedge clk);
         clear_ctrl();
         check(clk_enabled, VEC[i][1], $sformatf("R6 R7 vec %0d status", i));
         tap_pulse(0, VEC[i][0], $sformatf("R8 R9 vec %0d counting", i));
      end
      wave_mode = 0; ldb_dis = 0; ldb_stop = 0; cmpc_dis = 0; cmpc_stop = 0;

      // R2: each internal tap, others not selected
      for (int s = 0; s < 5; s++) begin
         src_sel = 3'(s);
         @(negedge clk); int_clk = ~(5'b1 << s);
         @(negedge clk); check(cnt_en, 1'b0, "R2 unselected taps");
         int_clk = '0;
         @(negedge clk);
         tap_pulse(s, 1'b1, "R2 selected tap");
      end

      // R10: tap held high gives one pulse
      src_sel = 3'd2;
      @(negedge clk); int_clk[2] = 1'b1;
      @(negedge clk); check(cnt_en, 1'b1, "R10 first cycle");
      @(negedge clk); check(cnt_en, 1'b0, "R10 second cycle");
      @(negedge clk); check(cnt_en, 1'b0, "R10 third cycle");
      int_clk[2] = 1'b0;
      @(negedge clk);

      // R3: invert picks falling edge
      src_sel = 3'd0; clk_inv = 1'b1;
      @(negedge clk); int_clk[0] = 1'b1;
      @(negedge clk); check(cnt_en, 1'b0, "R3 rising ignored");
      int_clk[0] = 1'b0;
      @(negedge clk); check(cnt_en, 1'b1, "R3 falling counts");
      @(negedge clk); check(cnt_en, 1'b0, "R3 pulse ends");
      clk_inv = 1'b0;

      // R4: external source latency through the synchronizer
      src_sel = 3'd5;
      @(negedge clk); ext_clk[0] = 1'b1;
      @(negedge clk); check(cnt_en, 1'b0, "R4 after edge k");
      @(negedge clk); check(cnt_en, 1'b0, "R4 after edge k+1");
      @(negedge clk); check(cnt_en, 1'b1, "R4 after edge k+2");
      @(negedge clk); check(cnt_en, 1'b0, "R4 after edge k+3");
      ext_clk[0] = 1'b0;
      repeat (4) @(negedge clk);
      src_sel = 3'd7;
      @(negedge clk); ext_clk[2] = 1'b1;
      repeat (3) @(negedge clk);
      check(cnt_en, 1'b1, "R4 third external input");
      ext_clk[2] = 1'b0;
      repeat (4) @(negedge clk);

      // R5: burst gating
      src_sel = 3'd0; burst_sel = 2'd2;
      tap_pulse(0, 1'b0, "R5 gate low blocks");
      ext_clk[1] = 1'b1;
      repeat (3) @(negedge clk);
      tap_pulse(0, 1'b1, "R5 gate high passes");
      burst_sel = 2'd3;
      tap_pulse(0, 1'b0, "R5 other gate low blocks");
      burst_sel = 2'd0;
      tap_pulse(0, 1'b1, "R5 no gate");
      ext_clk[1] = 1'b0;

      // R9: disable stops, re-enable leaves stopped
      @(negedge clk); cmd_disable = 1'b1;
      @(negedge clk); clear_ctrl(); cmd_enable = 1'b1;
      @(negedge clk); clear_ctrl();
      check(clk_enabled, 1'b1, "R9 re-enabled");
      tap_pulse(0, 1'b0, "R9 stopped after re-enable");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule